// File: doc/BRIEF.md
# Four-Buffer In-Order Packet Receiver

This block is the receive half of one serial lane. It takes the decoded 32-bit word stream, finds packet boundaries with a start marker, and checks two checksums. The first is a header check word that protects the buffer index. The second is a tail word that covers the payload. A data packet that passes the header check is written straight into one of four receive buffers, picked by the index in its header. When the tail also passes, that buffer is marked full and a one-cycle acknowledgement carrying the index goes to the local transmitter.

The consumer sees the buffers strictly in index order (0, 1, 2, 3, 0, ...). If one packet is lost, later good packets wait in their buffers. When the retransmission of the missing packet arrives, the waiting buffers are released one after another with no gap. A retransmission aimed at a buffer that still holds unread data never touches that buffer. A saturating counter records every checksum failure.

The parser is a four-state machine:
- `S_IDLE` waits for a start word.
- `S_HCHK` expects the header check word.
- `S_BODY` takes the payload words.
- `S_TAIL` expects the payload sum.

Its transitions are:
- start (any state → `S_HCHK` on a word marked start).
- header-pass-data (`S_HCHK` → `S_BODY`).
- header-pass-service or header-fail (`S_HCHK` → `S_IDLE`).
- body-last (`S_BODY` → `S_TAIL` on the last payload word).
- tail-done (`S_TAIL` → `S_IDLE`).

Top module: `rxq_lane_rx`

## Requirements
- R1: A packet begins with a word marked by `in_sof`. Its header has these fields: index in bits [1:0], title in [5:2], user flags in [13:6], and kind in [15:14], where 2'b01 is data and 2'b10 is service. The next word must equal the bitwise inverse of the header. A data packet then carries `PKT_WORDS` payload words (default 256). Its final word must equal the payload sum modulo 2^32. A service packet ends after its header check word.
- R2: If the header check word does not match, the packet is discarded. No buffer is written, no flags are output, no acknowledgement is sent, and the error counter rises by one.
- R3: A fresh data packet whose tail matches marks its buffer full. `ack_valid` is then high for exactly one cycle, with `ack_idx` equal to the header index, in the cycle after the tail word.
- R4: If a data packet's tail does not match, its buffer is not marked full, no acknowledgement is sent, and the error counter rises by one.
- R5: A data packet for a buffer that holds unread data leaves that buffer's contents unchanged. If its tail matches, it is acknowledged again.
- R6: `rx_ready` is high only while the buffer at the read pointer is full. The read pointer starts at 0 after reset and steps through 0, 1, 2, 3 and back to 0. Full buffers after an empty one are held back. Once the gap is filled, they are released on consecutive end-of-frames with no idle cycle between them.
- R7: While ready, `rx_data` shows the current word of the released buffer. `rx_rd` advances to the next word and holds at the last word. `rx_eof` frees the buffer and advances the pointer, and it may come before all words are read. `rx_rd` and `rx_eof` have no effect while `rx_ready` is low.
- R8: `rx_title` shows the title of the packet held in the released buffer.
- R9: When a header check passes, for either kind, `flag_data` carries the header flags with `flag_we` high for one cycle. A service packet never makes data ready.
- R10: `crc_err_cnt` counts header and tail failures and saturates at 255.
- R11: A start word in the middle of a packet abandons the partial packet, which is never acknowledged or released, and starts a new parse.
- R12: After reset, `rx_ready`, `ack_valid` and `flag_we` are low and `crc_err_cnt` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Incoming word valid |
| in_sof | input | 1 | Incoming word is a packet header |
| in_data | input | 32 | Incoming word |
| rx_ready | output | 1 | Released buffer available to consumer |
| rx_data | output | 32 | Current word of released buffer |
| rx_title | output | 4 | Title of released buffer |
| rx_rd | input | 1 | Advance to next word |
| rx_eof | input | 1 | Finish and free released buffer |
| flag_we | output | 1 | User flags strobe |
| flag_data | output | 8 | Received user flags |
| ack_valid | output | 1 | Acknowledge strobe for local transmitter |
| ack_idx | output | 2 | Acknowledged buffer index |
| crc_err_cnt | output | 8 | Saturating checksum failure count |

## Verification
The assertions check on every cycle the properties that hold locally:
- payload writes and buffer commits only ever target empty buffers, so a held buffer cannot be overwritten.
- acknowledgements are single-cycle pulses.
- the read position does not move while nothing is released.
- the error count stays at 255 once it has saturated.

Only the bench scenarios can show the behaviours that span whole packets:
- the order of release, including holding back later buffers and releasing them back to back after a retransmission.
- that the payload sum and the header inverse are judged correctly.
- that a duplicate leaves the held data intact.
- that a restarted packet leaves no trace.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
    localparam int IDX_W    = 2;
    localparam int NBUF     = 1 << IDX_W;
    localparam int TITLE_W  = 4;
    localparam int FLAG_W   = 8;
    localparam int WORD_W   = 32;
    localparam int KIND_W   = 2;
    localparam int IDX_LSB   = 0;
    localparam int TITLE_LSB = IDX_LSB + IDX_W;
    localparam int FLAG_LSB  = TITLE_LSB + TITLE_W;
    localparam int KIND_LSB  = FLAG_LSB + FLAG_W;

    typedef enum logic [KIND_W-1:0] {
        KIND_NONE = 2'b00,
        KIND_DATA = 2'b01,
        KIND_SVC  = 2'b10,
        KIND_RSVD = 2'b11
    } kind_e;

    typedef enum logic [1:0] {
        S_IDLE,
        S_HCHK,
        S_BODY,
        S_TAIL
    } pstate_e;
endpackage

// File: rtl/rxq_parser.sv
module rxq_parser
    import rxq_pkg::*;
#(
    parameter int PKT_WORDS = 256,
    localparam int OFF_W = $clog2(PKT_WORDS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic                in_sof,
    input  logic [WORD_W-1:0]   in_data,
    input  logic [NBUF-1:0]     buf_full,
    output logic                wr_en,
    output logic [IDX_W-1:0]    wr_buf,
    output logic [OFF_W-1:0]    wr_off,
    output logic [WORD_W-1:0]   wr_data,
    output logic                commit_en,
    output logic [IDX_W-1:0]    commit_idx,
    output logic [TITLE_W-1:0]  commit_title,
    output logic                ack_valid,
    output logic [IDX_W-1:0]    ack_idx,
    output logic                flag_we,
    output logic [FLAG_W-1:0]   flag_data,
    output logic                chk_err
);
    localparam logic [OFF_W-1:0] LAST_OFF = OFF_W'(PKT_WORDS - 1);

    pstate_e             state_q, state_d;
    logic [WORD_W-1:0]   hdr_q, hdr_d;
    logic [OFF_W-1:0]    cnt_q, cnt_d;
    logic [WORD_W-1:0]   sum_q, sum_d;
    logic                dup_q, dup_d;

    logic [IDX_W-1:0]    hdr_idx;
    logic [TITLE_W-1:0]  hdr_title;
    logic [FLAG_W-1:0]   hdr_flags;
    kind_e               hdr_kind;
    logic                word_in, hdr_ok, hchk_hit, tail_hit, tail_ok;
    logic                ack_d, commit_d, err_d, flag_d;

    assign hdr_idx   = hdr_q[IDX_LSB +: IDX_W];
    assign hdr_title = hdr_q[TITLE_LSB +: TITLE_W];
    assign hdr_flags = hdr_q[FLAG_LSB +: FLAG_W];
    assign hdr_kind  = kind_e'(hdr_q[KIND_LSB +: KIND_W]);

    assign word_in  = in_valid && !in_sof;
    assign hdr_ok   = (in_data == ~hdr_q);
    assign hchk_hit = word_in && (state_q == S_HCHK);
    assign tail_hit = word_in && (state_q == S_TAIL);
    assign tail_ok  = (in_data == sum_q);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            hdr_q   <= '0;
            cnt_q   <= '0;
            sum_q   <= '0;
            dup_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            hdr_q   <= hdr_d;
            cnt_q   <= cnt_d;
            sum_q   <= sum_d;
            dup_q   <= dup_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        hdr_d   = hdr_q;
        cnt_d   = cnt_q;
        sum_d   = sum_q;
        dup_d   = dup_q;
        if (in_valid && in_sof) begin
            hdr_d   = in_data;
            state_d = S_HCHK;
        end else if (in_valid) begin
            unique case (state_q)
                S_IDLE: begin
                    state_d = S_IDLE;
                end
                S_HCHK: begin
                    if (hdr_ok && hdr_kind == KIND_DATA) begin
                        state_d = S_BODY;
                        cnt_d   = '0;
                        sum_d   = '0;
                        dup_d   = buf_full[hdr_idx];
                    end else begin
                        state_d = S_IDLE;
                    end
                end
                S_BODY: begin
                    sum_d = sum_q + in_data;
                    cnt_d = cnt_q + 1'b1;
                    if (cnt_q == LAST_OFF) begin
                        state_d = S_TAIL;
                    end
                end
                S_TAIL: begin
                    state_d = S_IDLE;
                end
                default: begin
                    state_d = S_IDLE;
                end
            endcase
        end
    end

    // Output decode
    always_comb begin
        wr_en    = word_in && (state_q == S_BODY) && !dup_q;
        wr_buf   = hdr_idx;
        wr_off   = cnt_q;
        wr_data  = in_data;
        ack_d    = tail_hit && tail_ok;
        commit_d = tail_hit && tail_ok && !dup_q;
        err_d    = (hchk_hit && !hdr_ok) || (tail_hit && !tail_ok);
        flag_d   = hchk_hit && hdr_ok;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_valid    <= 1'b0;
            ack_idx      <= '0;
            commit_en    <= 1'b0;
            commit_idx   <= '0;
            commit_title <= '0;
            flag_we      <= 1'b0;
            flag_data    <= '0;
            chk_err      <= 1'b0;
        end else begin
            ack_valid    <= ack_d;
            ack_idx      <= hdr_idx;
            commit_en    <= commit_d;
            commit_idx   <= hdr_idx;
            commit_title <= hdr_title;
            flag_we      <= flag_d;
            flag_data    <= hdr_flags;
            chk_err      <= err_d;
        end
    end

    AST_WRITE_ONLY_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !buf_full[wr_buf]);  // R5
    AST_ACK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        ack_valid |=> !ack_valid);  // R3
endmodule

// File: rtl/rxq_store.sv
module rxq_store
    import rxq_pkg::*;
#(
    parameter int PKT_WORDS = 256,
    localparam int OFF_W = $clog2(PKT_WORDS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [IDX_W-1:0]    wr_buf,
    input  logic [OFF_W-1:0]    wr_off,
    input  logic [WORD_W-1:0]   wr_data,
    input  logic                commit_en,
    input  logic [IDX_W-1:0]    commit_idx,
    input  logic [TITLE_W-1:0]  commit_title,
    output logic [NBUF-1:0]     buf_full,
    output logic                rx_ready,
    output logic [WORD_W-1:0]   rx_data,
    output logic [TITLE_W-1:0]  rx_title,
    input  logic                rx_rd,
    input  logic                rx_eof
);
    localparam logic [OFF_W-1:0] LAST_OFF = OFF_W'(PKT_WORDS - 1);

    logic [WORD_W-1:0]  mem_q [NBUF][PKT_WORDS];
    logic [TITLE_W-1:0] title_arr [NBUF];
    logic [IDX_W-1:0]   rd_ptr;
    logic [OFF_W-1:0]   rd_off;
    logic               release_now;

    assign release_now = rx_ready && rx_eof;

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[wr_buf][wr_off] <= wr_data;
        end
    end

    for (genvar b = 0; b < NBUF; b++) begin : g_buf
        logic               full_q;
        logic [TITLE_W-1:0] title_q;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                full_q  <= 1'b0;
                title_q <= '0;
            end else if (commit_en && commit_idx == IDX_W'(b)) begin
                full_q  <= 1'b1;
                title_q <= commit_title;
            end else if (release_now && rd_ptr == IDX_W'(b)) begin
                full_q  <= 1'b0;
            end
        end
        assign buf_full[b]  = full_q;
        assign title_arr[b] = title_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            rd_off <= '0;
        end else if (release_now) begin
            rd_ptr <= rd_ptr + 1'b1;
            rd_off <= '0;
        end else if (rx_ready && rx_rd && rd_off != LAST_OFF) begin
            rd_off <= rd_off + 1'b1;
        end
    end

    assign rx_ready = buf_full[rd_ptr];
    assign rx_data  = mem_q[rd_ptr][rd_off];
    assign rx_title = title_arr[rd_ptr];

    AST_COMMIT_TO_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        commit_en |-> !buf_full[commit_idx]);  // R5
    AST_READ_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_ready |=> ($stable(rd_ptr) && $stable(rd_off)));  // R7
endmodule

// File: rtl/rxq_errcnt.sv
module rxq_errcnt #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (inc && count != CNT_MAX) begin
            count <= count + 1'b1;
        end
    end

    AST_CNT_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
        (count == CNT_MAX) |=> (count == CNT_MAX));  // R10
    AST_CNT_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !inc |=> $stable(count));  // R10
endmodule

// File: rtl/rxq_lane_rx.sv
module rxq_lane_rx
    import rxq_pkg::*;
#(
    parameter int PKT_WORDS = 256,
    parameter int ERR_W     = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic         in_sof,
    input  logic [31:0]  in_data,
    output logic         rx_ready,
    output logic [31:0]  rx_data,
    output logic [3:0]   rx_title,
    input  logic         rx_rd,
    input  logic         rx_eof,
    output logic         flag_we,
    output logic [7:0]   flag_data,
    output logic         ack_valid,
    output logic [1:0]   ack_idx,
    output logic [7:0]   crc_err_cnt
);
    localparam int OFF_W = $clog2(PKT_WORDS);

    logic                wr_en;
    logic [IDX_W-1:0]    wr_buf;
    logic [OFF_W-1:0]    wr_off;
    logic [WORD_W-1:0]   wr_data;
    logic                commit_en;
    logic [IDX_W-1:0]    commit_idx;
    logic [TITLE_W-1:0]  commit_title;
    logic [NBUF-1:0]     buf_full;
    logic                chk_err;
    logic [ERR_W-1:0]    err_count;

    rxq_parser #(.PKT_WORDS(PKT_WORDS)) u_parser (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_valid     (in_valid),
        .in_sof       (in_sof),
        .in_data      (in_data),
        .buf_full     (buf_full),
        .wr_en        (wr_en),
        .wr_buf       (wr_buf),
        .wr_off       (wr_off),
        .wr_data      (wr_data),
        .commit_en    (commit_en),
        .commit_idx   (commit_idx),
        .commit_title (commit_title),
        .ack_valid    (ack_valid),
        .ack_idx      (ack_idx),
        .flag_we      (flag_we),
        .flag_data    (flag_data),
        .chk_err      (chk_err)
    );

    rxq_store #(.PKT_WORDS(PKT_WORDS)) u_store (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .wr_buf       (wr_buf),
        .wr_off       (wr_off),
        .wr_data      (wr_data),
        .commit_en    (commit_en),
        .commit_idx   (commit_idx),
        .commit_title (commit_title),
        .buf_full     (buf_full),
        .rx_ready     (rx_ready),
        .rx_data      (rx_data),
        .rx_title     (rx_title),
        .rx_rd        (rx_rd),
        .rx_eof       (rx_eof)
    );

    rxq_errcnt #(.CNT_W(ERR_W)) u_errcnt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (chk_err),
        .count (err_count)
    );

    assign crc_err_cnt = 8'(err_count);
endmodule

// File: tb/rxq_lane_rx_bench.sv
module rxq_lane_rx_bench;
    localparam int NW = 256;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid, in_sof;
    logic [31:0] in_data;
    logic        rx_ready;
    logic [31:0] rx_data;
    logic [3:0]  rx_title;
    logic        rx_rd, rx_eof;
    logic        flag_we;
    logic [7:0]  flag_data;
    logic        ack_valid;
    logic [1:0]  ack_idx;
    logic [7:0]  crc_err_cnt;

    int checks = 0;
    int fails  = 0;
    int ack_cnt = 0;
    int flag_cnt = 0;
    logic [1:0] last_ack = '0;
    logic [7:0] last_flag = '0;
    bit done = 0;

    always #4 clk = ~clk;

    rxq_lane_rx #(.PKT_WORDS(NW)) u_rxq_lane_rx (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
        .in_data(in_data), .rx_ready(rx_ready), .rx_data(rx_data),
        .rx_title(rx_title), .rx_rd(rx_rd), .rx_eof(rx_eof),
        .flag_we(flag_we), .flag_data(flag_data), .ack_valid(ack_valid),
        .ack_idx(ack_idx), .crc_err_cnt(crc_err_cnt)
    );

    always @(negedge clk) begin
        if (ack_valid) begin ack_cnt++; last_ack = ack_idx; end
        if (flag_we)   begin flag_cnt++; last_flag = flag_data; end
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mkhdr(input logic [1:0] idx, input logic [3:0] title,
                                          input logic [7:0] flags, input logic [1:0] kind);
        return {16'h0, kind, flags, title, idx};
    endfunction

    task automatic put(input logic sof, input logic [31:0] w);
        @(negedge clk);
        in_valid = 1'b1; in_sof = sof; in_data = w;
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        in_valid = 1'b0; in_sof = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic send_pkt(input logic [1:0] idx, input logic [3:0] title, input logic [7:0] flags,
                            input logic [31:0] base, input bit bad_hdr, input bit bad_tail);
        logic [31:0] h, s;
        h = mkhdr(idx, title, flags, 2'b01);
        s = '0;
        put(1'b1, h);
        put(1'b0, bad_hdr ? (~h ^ 32'h10) : ~h);
        for (int i = 0; i < NW; i++) begin
            put(1'b0, base + i);
            s = s + base + i;
        end
        put(1'b0, bad_tail ? s + 1 : s);
        idle(3);
    endtask

    task automatic consume(input logic [31:0] base, input logic [3:0] title,
                           input int nread, input string tag);
        int bad;
        logic [31:0] got;
        bad = 0; got = '0;
        for (int w = 0; w < 40 && !rx_ready; w++) @(negedge clk);
        chk(rx_ready === 1'b1, {tag, " ready"}, rx_ready, 1);
        chk(rx_title === title, {tag, " R8 title"}, rx_title, title);
        for (int i = 0; i < nread; i++) begin
            if (rx_data !== base + i && bad == 0) got = rx_data;
            if (rx_data !== base + i) bad++;
            rx_rd = (i != nread - 1);
            @(negedge clk);
        end
        rx_rd = 1'b0;
        chk(bad == 0, {tag, " R7 data"}, got, base);
        rx_eof = 1'b1;
        @(negedge clk);
        rx_eof = 1'b0;
    endtask

    task automatic t_reset;
        chk(rx_ready === 1'b0, "R12 rx_ready", rx_ready, 0);
        chk(ack_valid === 1'b0 && flag_we === 1'b0, "R12 strobes", {ack_valid, flag_we}, 0);
        chk(crc_err_cnt === 8'd0, "R12 err count", crc_err_cnt, 0);
    endtask

    task automatic t_basic;
        send_pkt(2'd0, 4'h3, 8'h5A, 32'h1000_0000, 0, 0);
        chk(ack_cnt == 1 && last_ack == 2'd0, "R3 ack idx0", ack_cnt, 1);
        chk(flag_cnt == 1 && last_flag == 8'h5A, "R9 flags", last_flag, 8'h5A);
        consume(32'h1000_0000, 4'h3, NW, "R1 basic");
    endtask

    task automatic t_reorder;
        send_pkt(2'd1, 4'h1, 8'h01, 32'h2000_0000, 0, 1);
        chk(ack_cnt == 1, "R4 no ack on bad tail", ack_cnt, 1);
        chk(crc_err_cnt == 8'd1, "R4 err count", crc_err_cnt, 1);
        send_pkt(2'd2, 4'h2, 8'h02, 32'h3000_0000, 0, 0);
        send_pkt(2'd3, 4'h4, 8'h03, 32'h4000_0000, 0, 0);
        chk(ack_cnt == 3 && last_ack == 2'd3, "R3 ack idx3", last_ack, 3);
        chk(rx_ready === 1'b0, "R6 held back", rx_ready, 0);
        send_pkt(2'd1, 4'h1, 8'h01, 32'h2000_0000, 0, 0);
        consume(32'h2000_0000, 4'h1, 5, "R7 early eof buf1");
        chk(rx_ready === 1'b1, "R6 back to back buf2", rx_ready, 1);
        consume(32'h3000_0000, 4'h2, NW, "R6 buf2");
        chk(rx_ready === 1'b1, "R6 back to back buf3", rx_ready, 1);
        consume(32'h4000_0000, 4'h4, NW, "R6 buf3");
        chk(rx_ready === 1'b0, "R6 drained", rx_ready, 0);
    endtask

    task automatic t_header_and_dup;
        int a0, f0;
        send_pkt(2'd0, 4'h6, 8'h11, 32'h5000_0000, 0, 0);
        a0 = ack_cnt; f0 = flag_cnt;
        send_pkt(2'd0, 4'h9, 8'h22, 32'h6000_0000, 1, 0);
        chk(ack_cnt == a0 && flag_cnt == f0, "R2 no ack no flag", ack_cnt - a0, 0);
        chk(crc_err_cnt == 8'd2, "R2 err count", crc_err_cnt, 2);
        send_pkt(2'd0, 4'h9, 8'h33, 32'h7000_0000, 0, 0);
        chk(ack_cnt == a0 + 1 && last_ack == 2'd0, "R5 dup re-ack", ack_cnt - a0, 1);
        consume(32'h5000_0000, 4'h6, NW, "R5 dup kept");
    endtask

    task automatic t_ignore_when_empty;
        rx_rd = 1'b1; rx_eof = 1'b1;
        repeat (3) @(negedge clk);
        rx_rd = 1'b0; rx_eof = 1'b0;
        chk(rx_ready === 1'b0, "R7 still empty", rx_ready, 0);
        send_pkt(2'd1, 4'hA, 8'h44, 32'h8000_0000, 0, 0);
        consume(32'h8000_0000, 4'hA, 3, "R7 ignored strobes");
    endtask

    task automatic t_restart_and_service;
        int a0;
        a0 = ack_cnt;
        put(1'b1, mkhdr(2'd2, 4'h5, 8'h55, 2'b01));
        put(1'b0, ~mkhdr(2'd2, 4'h5, 8'h55, 2'b01));
        for (int i = 0; i < 10; i++) put(1'b0, 32'hDEAD_0000 + i);
        send_pkt(2'd2, 4'hC, 8'h66, 32'h9000_0000, 0, 0);
        chk(ack_cnt == a0 + 1, "R11 single ack", ack_cnt - a0, 1);
        consume(32'h9000_0000, 4'hC, NW, "R11 second packet");
        put(1'b1, mkhdr(2'd3, 4'h7, 8'h77, 2'b10));
        put(1'b0, ~mkhdr(2'd3, 4'h7, 8'h77, 2'b10));
        idle(3);
        chk(last_flag == 8'h77, "R9 service flags", last_flag, 8'h77);
        chk(rx_ready === 1'b0 && ack_cnt == a0 + 1, "R9 service no data", rx_ready, 0);
    endtask

    task automatic t_saturate;
        for (int k = 0; k < 260; k++) begin
            put(1'b1, mkhdr(2'd3, 4'h0, 8'h00, 2'b01));
            put(1'b0, 32'h0);
        end
        idle(3);
        chk(crc_err_cnt == 8'd255, "R10 saturate", crc_err_cnt, 255);
    endtask

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; in_sof = 1'b0; in_data = '0;
        rx_rd = 1'b0; rx_eof = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_basic;
        t_reorder;
        t_header_and_dup;
        t_ignore_when_empty;
        t_restart_and_service;
        t_saturate;
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule